// File: doc/BRIEF.md
# Periodic Tick Down-Counter Timer

This block produces a steady heartbeat for a processor subsystem. A 24-bit counter counts down from a programmed start value. When it reaches zero it reloads from the stored start value, so the heartbeat period is exactly the start value plus one counting step. Each time the count passes through zero, the block latches a sticky flag and can raise an interrupt pulse. Counting steps come either from every core clock or from an internal strobe that fires once every eight core clocks.

Software reaches the block through three word registers on a plain read/write strobe bus: control, reload and current count. The register index is `bus_addr`. Read data is combinational while `bus_rd` is high, and writes take effect at the clock edge that ends the strobe cycle. The usual bring-up order is to write the reload value, then clear the current count by writing it, then set the run and interrupt-enable bits.

This is a register-mapped control block with no streaming data path, so no port uses a valid/ready handshake. Every bus access completes in one cycle with no back-pressure.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and current-count registers all read zero (index 0, 1 and 2) and `irq` is low.
- R2: A write to the reload register (index 1) keeps bits 23:0 of the data and drops bits 31:24. A read returns the stored value zero-extended.
- R3: With run (control bit 0) and full-rate source (control bit 2) both set, the count falls by one every core clock. Wraps occur every reload+1 clocks.
- R4: With control bit 2 clear, the count steps once every 8 core clocks. Each time run is enabled, the divider phase starts fresh, so the first step lands 8 clocks after the enabling write takes effect.
- R5: While run is clear, the count holds its value.
- R6: A wrap sets the sticky flag at control bit 16. A read of the control register returns the flag and clears it.
- R7: If a wrap and a control-register read fall in the same cycle, the read returns the old flag and the flag ends up set.
- R8: `irq` is a one-cycle pulse, issued in the cycle after each wrap, and only while interrupt enable (control bit 1) is set. Wraps still set the flag when interrupts are disabled.
- R9: A write of any data to the current-count register (index 2) clears the count and the flag. The next counting step loads the reload value without signalling a wrap.
- R10: With a reload value of zero, the count stays at zero and no wrap or interrupt occurs.
- R11: A read of the current-count register returns the live count in bits 23:0, with bits 31:24 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe for the selected register |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_addr | input | 2 | Register index: 0 control, 1 reload, 2 current count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | One-cycle interrupt pulse per wrap |

## Verification
Two pairs of events can land in the same cycle, and both are tested.

The first pair is a wrap and a control-register read. The bench learns the wrap phase from an observed interrupt pulse. It then places a control read exactly on the edge that registers the next wrap. That read must return a cleared flag, the interrupt must still appear, and a later read must find the flag set.

The second pair is a current-count write and a counting step. Here the write must win. The bench checks this by clearing the count and then timing the first interrupt from the enabling write: it must arrive after reload+1 steps, not after a single step.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int REG_IDX_W = 2;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2
  } reg_sel_e;

  // bit positions inside the control word
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_IEN  = 1;
  localparam int CTRL_FULL = 2;
  localparam int CTRL_FLAG = 16;
endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic strobe
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign strobe = run;
    end else begin : g_div
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
        if (!rst_n || !run)                phase <= '0;
        else if (phase == PW'(DIV - 1))    phase <= '0;
        else                               phase <= phase + 1'b1;
      end
      assign strobe = run && (phase == PW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  // a wrap is the 1 -> 0 transition; a clear in the same cycle wins
  assign wrap = step && !clear && (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)               count <= '0;
    else if (clear)           count <= '0;
    else if (step) begin
      if (count == '0)        count <= reload;
      else                    count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int DIV    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [REG_IDX_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq
);
  logic             ctrl_run, ctrl_ien, ctrl_full, wrap_flag;
  logic [CNT_W-1:0] reload_q, count;
  logic             div_strobe, step, wrap;
  logic             ctrl_wr, reload_wr, cur_wr, ctrl_rd;

  assign ctrl_wr   = bus_wr && (bus_addr == REG_CTRL);
  assign reload_wr = bus_wr && (bus_addr == REG_RELOAD);
  assign cur_wr    = bus_wr && (bus_addr == REG_CURRENT);
  assign ctrl_rd   = bus_rd && (bus_addr == REG_CTRL);

  tick_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_run), .strobe(div_strobe)
  );

  assign step = ctrl_run && (ctrl_full || div_strobe);

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .clear(cur_wr),
    .reload(reload_q), .count(count), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_run  <= 1'b0;
      ctrl_ien  <= 1'b0;
      ctrl_full <= 1'b0;
      reload_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_run  <= bus_wdata[CTRL_RUN];
        ctrl_ien  <= bus_wdata[CTRL_IEN];
        ctrl_full <= bus_wdata[CTRL_FULL];
      end
      if (reload_wr) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // flag: clear-by-count-write first, then wrap beats read-clear
  always_ff @(posedge clk) begin
    if (!rst_n)       wrap_flag <= 1'b0;
    else if (cur_wr)  wrap_flag <= 1'b0;
    else if (wrap)    wrap_flag <= 1'b1;
    else if (ctrl_rd) wrap_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= wrap && ctrl_ien;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CTRL: begin
        bus_rdata[CTRL_RUN]  = ctrl_run;
        bus_rdata[CTRL_IEN]  = ctrl_ien;
        bus_rdata[CTRL_FULL] = ctrl_full;
        bus_rdata[CTRL_FLAG] = wrap_flag;
      end
      REG_RELOAD:  bus_rdata = DATA_W'(reload_q);
      REG_CURRENT: bus_rdata = DATA_W'(count);
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             ctrl_run,
  input logic             ctrl_ien,
  input logic             wrap_flag,
  input logic             cur_wr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload_q
);
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctrl_ien));

  assert_irq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wrap_flag);

  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctrl_run) && !$past(cur_wr)) |-> (count == $past(count)));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (count == '0));

  assert_zero_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q == '0 && count == '0) |=> (count == '0));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ctrl_run(ctrl_run),
  .ctrl_ien(ctrl_ien), .wrap_flag(wrap_flag), .cur_wr(cur_wr),
  .count(count), .reload_q(reload_q)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam logic [1:0]  A_CTRL = 2'd0, A_RELOAD = 2'd1, A_CUR = 2'd2;
  localparam logic [31:0] RUN = 32'h1, IEN = 32'h2, FULL = 32'h4;
  localparam int FLAG = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  int cyc = 0;
  int n_irq = 0, first_irq = 0, last_irq = 0, gap = 0, dbl = 0;
  logic irq_prev = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) begin
        if (irq_prev) dbl++;
        if (n_irq == 0) first_irq = cyc;
        else gap = cyc - last_irq;
        last_irq = cyc;
        n_irq++;
      end
      irq_prev = irq;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // caller is at a falling edge
  task automatic rd_now(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic clr_mon();
    @(posedge clk);
    n_irq = 0; gap = 0; dbl = 0;
  endtask

  task automatic setup(input logic [31:0] rl);
    wr(A_CTRL, 32'h0);
    wr(A_RELOAD, rl);
    wr(A_CUR, 32'h0);
  endtask

  // enable at a falling edge and return the cycle stamp of that edge
  task automatic enable_timed(input logic [31:0] c, output int t0);
    @(negedge clk);
    bus_addr = A_CTRL; bus_wdata = c; bus_wr = 1'b1; t0 = cyc;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v);   chk("R1 ctrl", v, 32'h0);
    rd(A_RELOAD, v); chk("R1 reload", v, 32'h0);
    rd(A_CUR, v);    chk("R1 current", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_reload_mask();
    logic [31:0] v;
    setup(32'hFFFF_FFFF);
    rd(A_RELOAD, v); chk("R2 reload upper bits dropped", v, 32'h00FF_FFFF);
    wr(A_RELOAD, 32'hA512_3456);
    rd(A_RELOAD, v); chk("R2 reload readback", v, 32'h0012_3456);
    wr(A_RELOAD, 32'h00FF_FFFF);
    wr(A_CTRL, RUN | FULL);
    repeat (4) @(negedge clk);
    rd(A_CUR, v);
    chk("R11 current upper byte zero", {24'h0, v[31:24]}, 32'h0);
    chk("R11 current near top", {31'h0, (v > 32'h00FF_FF00)}, 32'h1);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_full_period();
    logic [31:0] v1, v2;
    int t0;
    setup(32'd4);
    clr_mon();
    enable_timed(RUN | IEN | FULL, t0);
    repeat (30) @(negedge clk);
    wr(A_CTRL, 32'h0);
    chk("R3 several wraps seen", {31'h0, (n_irq >= 4)}, 32'h1);
    chk("R3 wrap spacing reload+1", gap, 32'd5);
    chk("R8 single-cycle pulse", dbl, 32'd0);
    setup(32'd100);
    wr(A_CTRL, RUN | FULL);
    rd(A_CUR, v1);
    rd(A_CUR, v2);
    wr(A_CTRL, 32'h0);
    chk("R3 counts down one per clock", v1 - v2, 32'd2);
  endtask

  task automatic t_divided();
    int t0;
    setup(32'd2);
    wr(A_CTRL, RUN);          // leave the divider mid-phase
    repeat (3) @(negedge clk);
    wr(A_CTRL, 32'h0);
    wr(A_CUR, 32'h0);
    clr_mon();
    enable_timed(RUN | IEN, t0);
    repeat (60) @(negedge clk);
    wr(A_CTRL, 32'h0);
    chk("R4 first wrap after fresh divider phase", first_irq - t0, 32'd25);
    chk("R4 divided wrap spacing", gap, 32'd24);
  endtask

  task automatic t_freeze();
    logic [31:0] v1, v2;
    setup(32'd1000);
    wr(A_CTRL, RUN | FULL);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_CUR, v1);
    repeat (6) @(negedge clk);
    rd(A_CUR, v2);
    chk("R5 count held while stopped", v2, v1);
    chk("R5 count had moved", {31'h0, (v1 != 0)}, 32'h1);
  endtask

  task automatic t_flag();
    logic [31:0] v;
    setup(32'd4);
    clr_mon();
    wr(A_CTRL, RUN | FULL);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'h0);
    chk("R8 no irq with enable clear", n_irq, 32'd0);
    rd(A_CTRL, v); chk("R6 flag set by wrap", {31'h0, v[FLAG]}, 32'h1);
    rd(A_CTRL, v); chk("R6 flag cleared by read", {31'h0, v[FLAG]}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    setup(32'd4);
    wr(A_CTRL, RUN | IEN | FULL);
    do @(negedge clk); while (!irq);
    @(negedge clk);
    rd_now(A_CTRL, v);
    chk("R6 read returns flag", {31'h0, v[FLAG]}, 32'h1);
    repeat (2) @(negedge clk);
    rd_now(A_CTRL, v);        // read lands on the wrap edge
    chk("R7 read on wrap edge returns old flag", {31'h0, v[FLAG]}, 32'h0);
    chk("R7 wrap happened on that edge", {31'h0, irq}, 32'h1);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v);
    chk("R7 flag survives coincident read", {31'h0, v[FLAG]}, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    int t0;
    setup(32'd4);
    wr(A_CTRL, RUN | FULL);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h0);
    wr(A_CUR, 32'hABCD_1234);
    rd(A_CUR, v);  chk("R9 count cleared by write", v, 32'h0);
    rd(A_CTRL, v); chk("R9 flag cleared by count write", {31'h0, v[FLAG]}, 32'h0);
    clr_mon();
    enable_timed(RUN | IEN | FULL, t0);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'h0);
    chk("R9 first step reloads without wrap", first_irq - t0, 32'd6);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    setup(32'd0);
    clr_mon();
    wr(A_CTRL, RUN | IEN | FULL);
    repeat (40) @(negedge clk);
    rd(A_CUR, v);
    wr(A_CTRL, 32'h0);
    chk("R10 count stays zero", v, 32'h0);
    chk("R10 no interrupts", n_irq, 32'd0);
    rd(A_CTRL, v);
    chk("R10 no wrap flag", {31'h0, v[FLAG]}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reload_mask();
    t_full_period();
    t_divided();
    t_freeze();
    t_flag();
    t_collide();
    t_clear();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule